// File: doc/BRIEF.md
# Supervisor control register bank

This block holds the control registers of a processor core that runs in user and supervisor modes. It keeps three stack pointers (user, interrupt and master), the source and destination function-code registers, the vector base register and a cache control register. Decode logic elsewhere in the core reaches these registers through three ports. A move-control port reads or writes one register, chosen by a 12-bit select code. An A7 port reads or updates the stack pointer that is active under the current status-register mode bits. An exception-entry port returns the status register to load, the status value to stack and the relocated vector address.

The block receives the live status register on `sr_i` and uses only bit 13 (S) and bit 12 (M) to choose a stack pointer. Registers that drive no logic in the core still hold what was written to them, filtered through their implemented-bit masks, so that software which probes the registers reads back what it expects.

Top module: `sys_ctl_regbank`

## Requirements
- R1: A write to select code 0x000 (source function code) or 0x001 (destination function code) stores bits 2:0 of the write data. A later read returns that value with bits 31:3 zero. Each register keeps its value until it is written again.
- R2: A write to select code 0x002 (cache control) stores only the bits set in `CACR_MASK` (default bits 1:0). A read returns the filtered value.
- R3: In supervisor mode, a select code other than 0x000, 0x001, 0x002, 0x800 (USP), 0x801 (VBR), 0x803 (MSP) or 0x804 (ISP) raises `mc_illegal_o` in the same cycle. The access returns zero on `mc_rdata_o` and changes no register.
- R4: A move-control access while S (sr_i bit 13) is 0 raises `mc_priv_o` and not `mc_illegal_o`, even when the code is unknown. The access returns zero and changes no register.
- R5: A7 maps to the user stack pointer when S=0, to the interrupt stack pointer when S=1 and M=0, and to the master stack pointer when S=1 and M=1. `a7_rdata_o` follows a change of `sr_i` in the same cycle. An A7 write lands in the register selected in the cycle of the write.
- R6: In supervisor mode, A7 and the move-control port see the same registers. A value written through one port is read back through the other port in the next cycle.
- R7: After reset every register reads zero, except the interrupt stack pointer, which holds `reset_sp_i`.
- R8: One cycle after `exc_valid_i`, `exc_done_o` is 1 for a single cycle. `exc_stacked_sr_o` then equals the `sr_i` value from the request cycle. `exc_new_sr_o` equals that value with bits 15 and 14 cleared and bit 13 set, so its low byte (the condition codes) matches the stacked value.
- R9: The vector base register stores and returns all 32 bits. One cycle after an exception request, `exc_vec_addr_o` equals VBR + 4 × `exc_vec_i`.
- R10: When a move-control write and an A7 write target the same stack pointer in one cycle, the move-control data is kept. When they target different stack pointers, both writes take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reset_sp_i | input | 32 | Initial interrupt stack pointer loaded during reset |
| sr_i | input | 16 | Live status register (bit 13 S, bit 12 M) |
| mc_valid_i | input | 1 | Move-control access in this cycle |
| mc_write_i | input | 1 | 1 = write, 0 = read |
| mc_code_i | input | 12 | Control register select code |
| mc_wdata_i | input | 32 | Move-control write data |
| mc_rdata_o | output | 32 | Move-control read data (combinational) |
| mc_illegal_o | output | 1 | Unknown select code in supervisor mode |
| mc_priv_o | output | 1 | Access attempted in user mode |
| a7_we_i | input | 1 | Write the active stack pointer |
| a7_wdata_i | input | 32 | A7 write data |
| a7_rdata_o | output | 32 | Active stack pointer value (combinational) |
| exc_valid_i | input | 1 | Exception entry request |
| exc_vec_i | input | 8 | Exception vector number |
| exc_done_o | output | 1 | Exception entry results valid |
| exc_new_sr_o | output | 16 | Status register to load at exception entry |
| exc_stacked_sr_o | output | 16 | Status register value to stack |
| exc_vec_addr_o | output | 32 | Relocated vector fetch address |

## Verification
The bench targets stack-pointer banking at the points where the S and M bits change. A design that latched the bank selection would return the previous stack pointer in the cycle of the switch. A design that left the interrupt stack pointer unreachable through A7 would lose a value written through one port before the other port read it. Filtered storage is probed by writing all ones. A design that kept every bit, or that dropped the function-code registers, would read back the wrong value or zero. Exception entry is checked on status values with trace bits set and condition codes nonzero; clearing condition-code bits during entry shows up as a mismatch between the stacked and new low bytes. The bench also covers same-cycle writes from both ports and unknown codes issued in user mode. A wrong priority or flag precedence in those cases corrupts a stack pointer or raises the wrong fault flag.

// File: rtl/sys_ctl_pkg.sv
package sys_ctl_pkg;
  localparam int CODE_W = 12;
  localparam int SR_W   = 16;
  localparam int SR_T1  = 15;
  localparam int SR_T0  = 14;
  localparam int SR_S   = 13;
  localparam int SR_M   = 12;
  localparam int NUM_SP = 3;   // 0 user, 1 interrupt, 2 master

  localparam logic [CODE_W-1:0] CODE_SFC  = 12'h000;
  localparam logic [CODE_W-1:0] CODE_DFC  = 12'h001;
  localparam logic [CODE_W-1:0] CODE_CACR = 12'h002;
  localparam logic [CODE_W-1:0] CODE_USP  = 12'h800;
  localparam logic [CODE_W-1:0] CODE_VBR  = 12'h801;
  localparam logic [CODE_W-1:0] CODE_MSP  = 12'h803;
  localparam logic [CODE_W-1:0] CODE_ISP  = 12'h804;

  typedef enum logic [2:0] {
    SEL_SFC  = 3'd0,
    SEL_DFC  = 3'd1,
    SEL_CACR = 3'd2,
    SEL_VBR  = 3'd3,
    SEL_USP  = 3'd4,
    SEL_ISP  = 3'd5,
    SEL_MSP  = 3'd6,
    SEL_NONE = 3'd7
  } ctl_sel_e;

  // Bank index of the stack pointer that A7 addresses.
  function automatic logic [1:0] active_sp_idx(input logic s, input logic m);
    if (!s)      return 2'd0;
    else if (!m) return 2'd1;
    else         return 2'd2;
  endfunction

  function automatic logic sel_is_sp(input ctl_sel_e sel);
    return (sel == SEL_USP) || (sel == SEL_ISP) || (sel == SEL_MSP);
  endfunction

  function automatic logic [1:0] sel_sp_idx(input ctl_sel_e sel);
    case (sel)
      SEL_ISP: return 2'd1;
      SEL_MSP: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  // Status register loaded at exception entry: trace off, supervisor on,
  // everything else (including the condition-code byte) untouched.
  function automatic logic [SR_W-1:0] entry_sr(input logic [SR_W-1:0] sr);
    logic [SR_W-1:0] r;
    r        = sr;
    r[SR_T1] = 1'b0;
    r[SR_T0] = 1'b0;
    r[SR_S]  = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/ctl_sel_decode.sv
module ctl_sel_decode
  import sys_ctl_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output ctl_sel_e          sel_o
);
  always_comb begin
    case (code_i)
      CODE_SFC:  sel_o = SEL_SFC;
      CODE_DFC:  sel_o = SEL_DFC;
      CODE_CACR: sel_o = SEL_CACR;
      CODE_USP:  sel_o = SEL_USP;
      CODE_VBR:  sel_o = SEL_VBR;
      CODE_MSP:  sel_o = SEL_MSP;
      CODE_ISP:  sel_o = SEL_ISP;
      default:   sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/aux_reg_file.sv
module aux_reg_file
  import sys_ctl_pkg::*;
#(
  parameter int            DW        = 32,
  parameter int            FC_W      = 3,
  parameter logic [DW-1:0] CACR_MASK = 32'h0000_0003
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  ctl_sel_e      sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] vbr_o,
  output logic [DW-1:0] rdata_o
);
  localparam int NUM_FC = 2;

  logic [DW-1:0] fc_rd [NUM_FC];
  logic [DW-1:0] cacr_q;
  logic [DW-1:0] vbr_q;

  generate
    for (genvar g = 0; g < NUM_FC; g++) begin : g_fc
      localparam ctl_sel_e MY_SEL = ctl_sel_e'(g);
      logic [FC_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       q <= '0;
        else if (wr_en && sel == MY_SEL)  q <= wdata[FC_W-1:0];
      end
      assign fc_rd[g] = (sel == MY_SEL) ? {{(DW-FC_W){1'b0}}, q} : '0;

      // R1: stored function code equals the low bits of the last write
      a_r1_fc_stores_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == MY_SEL) |=> q == $past(wdata[FC_W-1:0]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cacr_q <= '0;
      vbr_q  <= '0;
    end else if (wr_en) begin
      if (sel == SEL_CACR) cacr_q <= wdata & CACR_MASK;
      if (sel == SEL_VBR)  vbr_q  <= wdata;
    end
  end

  assign vbr_o   = vbr_q;
  assign rdata_o = fc_rd[0] | fc_rd[1]
                 | ((sel == SEL_CACR) ? cacr_q : '0)
                 | ((sel == SEL_VBR)  ? vbr_q  : '0);

  // R2: no unimplemented cache-control bit is ever held
  a_r2_cacr_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (cacr_q & ~CACR_MASK) == '0);

  // R3: without an accepted write nothing in this file moves
  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cacr_q) && $stable(vbr_q)
               && $stable(g_fc[0].q) && $stable(g_fc[1].q));
endmodule

// File: rtl/stack_ptr_bank.sv
module stack_ptr_bank
  import sys_ctl_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] reset_sp,
  input  logic          s_bit,
  input  logic          m_bit,
  input  logic          mc_wr_en,
  input  ctl_sel_e      sel,
  input  logic [DW-1:0] mc_wdata,
  input  logic          a7_we,
  input  logic [DW-1:0] a7_wdata,
  output logic [DW-1:0] a7_rdata,
  output logic [DW-1:0] mc_rdata
);
  logic [1:0]    act_idx;
  logic [1:0]    mc_idx;
  logic          mc_is_sp;
  logic          sp_collide;
  logic [DW-1:0] sp_q [NUM_SP];

  assign act_idx    = active_sp_idx(s_bit, m_bit);
  assign mc_idx     = sel_sp_idx(sel);
  assign mc_is_sp   = sel_is_sp(sel);
  assign sp_collide = mc_wr_en && mc_is_sp && a7_we && (mc_idx == act_idx);

  generate
    for (genvar g = 0; g < NUM_SP; g++) begin : g_sp
      logic [DW-1:0] q;
      logic          mc_hit;
      logic          a7_hit;
      assign mc_hit = mc_wr_en && mc_is_sp && (mc_idx == 2'(g));
      assign a7_hit = a7_we && (act_idx == 2'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= (g == 1) ? reset_sp : '0;
        else if (mc_hit) q <= mc_wdata;
        else if (a7_hit) q <= a7_wdata;
      end
      assign sp_q[g] = q;
    end
  endgenerate

  function automatic logic [DW-1:0] sp_at(input logic [1:0] i);
    case (i)
      2'd1:    return sp_q[1];
      2'd2:    return sp_q[2];
      default: return sp_q[0];
    endcase
  endfunction

  assign a7_rdata = sp_at(act_idx);
  assign mc_rdata = mc_is_sp ? sp_at(mc_idx) : '0;

  // R10: move-control data wins a same-register collision
  a_r10_mc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sp_collide |=> sp_at($past(mc_idx)) == $past(mc_wdata));

  // R5: an uncontested A7 write lands in the bank chosen in its cycle
  a_r5_a7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (a7_we && !(mc_wr_en && mc_is_sp)) |=> sp_at($past(act_idx)) == $past(a7_wdata));

  // R4: with no write from either port the bank is stable
  a_r4_sp_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!mc_wr_en && !a7_we) |=> $stable(sp_q[0]) && $stable(sp_q[1]) && $stable(sp_q[2]));
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import sys_ctl_pkg::*;
#(
  parameter int DW    = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_valid,
  input  logic [VEC_W-1:0] vec,
  input  logic [SR_W-1:0]  sr,
  input  logic [DW-1:0]    vbr,
  output logic             done,
  output logic [SR_W-1:0]  new_sr,
  output logic [SR_W-1:0]  stacked_sr,
  output logic [DW-1:0]    vec_addr
);
  localparam int VEC_SHIFT = 2;

  function automatic logic [DW-1:0] reloc_addr(input logic [DW-1:0] base,
                                               input logic [VEC_W-1:0] v);
    return base + (DW'(v) << VEC_SHIFT);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      new_sr     <= '0;
      stacked_sr <= '0;
      vec_addr   <= '0;
    end else begin
      done <= exc_valid;
      if (exc_valid) begin
        stacked_sr <= sr;
        new_sr     <= entry_sr(sr);
        vec_addr   <= reloc_addr(vbr, vec);
      end
    end
  end

  // R8: condition codes agree between live and stacked status
  a_r8_ccr_agree: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> new_sr[7:0] == stacked_sr[7:0] && new_sr[SR_S]
             && !new_sr[SR_T1] && !new_sr[SR_T0]);

  // R8: stacked value is the status from the request cycle
  a_r8_stacks_request_sr: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> done && stacked_sr == $past(sr));
endmodule

// File: rtl/sys_ctl_regbank.sv
module sys_ctl_regbank
  import sys_ctl_pkg::*;
#(
  parameter int            DW        = 32,
  parameter int            FC_W      = 3,
  parameter int            VEC_W     = 8,
  parameter logic [DW-1:0] CACR_MASK = 32'h0000_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     reset_sp_i,
  input  logic [SR_W-1:0]   sr_i,
  input  logic              mc_valid_i,
  input  logic              mc_write_i,
  input  logic [CODE_W-1:0] mc_code_i,
  input  logic [DW-1:0]     mc_wdata_i,
  output logic [DW-1:0]     mc_rdata_o,
  output logic              mc_illegal_o,
  output logic              mc_priv_o,
  input  logic              a7_we_i,
  input  logic [DW-1:0]     a7_wdata_i,
  output logic [DW-1:0]     a7_rdata_o,
  input  logic              exc_valid_i,
  input  logic [VEC_W-1:0]  exc_vec_i,
  output logic              exc_done_o,
  output logic [SR_W-1:0]   exc_new_sr_o,
  output logic [SR_W-1:0]   exc_stacked_sr_o,
  output logic [DW-1:0]     exc_vec_addr_o
);
  ctl_sel_e      sel;
  logic          super_mode;
  logic          sel_known;
  logic          mc_ok;
  logic          mc_wr_en;
  logic [DW-1:0] aux_rd;
  logic [DW-1:0] sp_rd;
  logic [DW-1:0] vbr;

  assign super_mode = sr_i[SR_S];
  assign sel_known  = (sel != SEL_NONE);
  assign mc_ok      = mc_valid_i && super_mode && sel_known;
  assign mc_wr_en   = mc_ok && mc_write_i;

  assign mc_priv_o    = mc_valid_i && !super_mode;
  assign mc_illegal_o = mc_valid_i && super_mode && !sel_known;
  assign mc_rdata_o   = mc_ok ? (aux_rd | sp_rd) : '0;

  ctl_sel_decode u_dec (
    .code_i (mc_code_i),
    .sel_o  (sel)
  );

  aux_reg_file #(.DW(DW), .FC_W(FC_W), .CACR_MASK(CACR_MASK)) u_aux (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mc_wr_en),
    .sel     (sel),
    .wdata   (mc_wdata_i),
    .vbr_o   (vbr),
    .rdata_o (aux_rd)
  );

  stack_ptr_bank #(.DW(DW)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .reset_sp (reset_sp_i),
    .s_bit    (sr_i[SR_S]),
    .m_bit    (sr_i[SR_M]),
    .mc_wr_en (mc_wr_en),
    .sel      (sel),
    .mc_wdata (mc_wdata_i),
    .a7_we    (a7_we_i),
    .a7_wdata (a7_wdata_i),
    .a7_rdata (a7_rdata_o),
    .mc_rdata (sp_rd)
  );

  exc_entry_unit #(.DW(DW), .VEC_W(VEC_W)) u_exc (
    .clk        (clk),
    .rst_n      (rst_n),
    .exc_valid  (exc_valid_i),
    .vec        (exc_vec_i),
    .sr         (sr_i),
    .vbr        (vbr),
    .done       (exc_done_o),
    .new_sr     (exc_new_sr_o),
    .stacked_sr (exc_stacked_sr_o),
    .vec_addr   (exc_vec_addr_o)
  );

  // R4: a user-mode access never reports an illegal code and returns zero
  a_r4_priv_precedence: assert property (@(posedge clk) disable iff (!rst_n)
    mc_priv_o |-> !mc_illegal_o && mc_rdata_o == '0);

  // R3: an unknown code returns zero data
  a_r3_illegal_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mc_illegal_o |-> mc_rdata_o == '0 && !mc_priv_o);
endmodule

// File: tb/sys_ctl_regbank_tb_top.sv
module sys_ctl_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] reset_sp;
  logic [15:0] sr;
  logic        mc_valid, mc_write;
  logic [11:0] mc_code;
  logic [31:0] mc_wdata, mc_rdata;
  logic        mc_illegal, mc_priv;
  logic        a7_we;
  logic [31:0] a7_wdata, a7_rdata;
  logic        exc_valid;
  logic [7:0]  exc_vec;
  logic        exc_done;
  logic [15:0] exc_new_sr, exc_stacked_sr;
  logic [31:0] exc_vec_addr;

  always #4 clk = ~clk;   // 125 MHz

  sys_ctl_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .reset_sp_i(reset_sp), .sr_i(sr),
    .mc_valid_i(mc_valid), .mc_write_i(mc_write), .mc_code_i(mc_code),
    .mc_wdata_i(mc_wdata), .mc_rdata_o(mc_rdata), .mc_illegal_o(mc_illegal),
    .mc_priv_o(mc_priv), .a7_we_i(a7_we), .a7_wdata_i(a7_wdata),
    .a7_rdata_o(a7_rdata), .exc_valid_i(exc_valid), .exc_vec_i(exc_vec),
    .exc_done_o(exc_done), .exc_new_sr_o(exc_new_sr),
    .exc_stacked_sr_o(exc_stacked_sr), .exc_vec_addr_o(exc_vec_addr)
  );

  // sig: 0 rdata, 1 illegal, 2 priv, 3 a7, 4 new sr, 5 stacked sr, 6 vec addr, 7 done
  typedef struct {
    int          cyc;
    string       req;
    int          sig;
    logic [31:0] exp;
  } item_t;

  item_t sbq[$];
  int    cyc_n  = 0;
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    finished = 1'b0;

  always @(posedge clk) cyc_n++;

  function automatic logic [31:0] observe(int sig);
    case (sig)
      0: return mc_rdata;
      1: return {31'd0, mc_illegal};
      2: return {31'd0, mc_priv};
      3: return a7_rdata;
      4: return {16'd0, exc_new_sr};
      5: return {16'd0, exc_stacked_sr};
      6: return exc_vec_addr;
      default: return {31'd0, exc_done};
    endcase
  endfunction

  // Monitor: pops items due this cycle and compares at the falling edge
  initial forever begin
    @(negedge clk);
    while (sbq.size() > 0 && sbq[0].cyc <= cyc_n) begin
      item_t it;
      logic [31:0] got;
      it  = sbq.pop_front();
      got = observe(it.sig);
      n_chk++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s sig%0d cycle %0d: got %h expected %h",
                 it.req, it.sig, it.cyc, got, it.exp);
      end
    end
  end

  task automatic idle_inputs();
    mc_valid = 0; mc_write = 0; mc_code = '0; mc_wdata = '0;
    a7_we = 0; a7_wdata = '0; exc_valid = 0; exc_vec = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic expect_at(int d, int sig, logic [31:0] v, string r);
    item_t it;
    it.cyc = cyc_n + d; it.req = r; it.sig = sig; it.exp = v;
    sbq.push_back(it);
  endtask

  task automatic sr_to(logic [15:0] v);
    step(); sr = v;
  endtask

  task automatic mc_wr(logic [11:0] c, logic [31:0] d);
    step(); mc_valid = 1; mc_write = 1; mc_code = c; mc_wdata = d;
  endtask

  task automatic mc_rd(logic [11:0] c, logic [31:0] e, string r);
    step(); mc_valid = 1; mc_code = c;
    expect_at(0, 0, e, r);
    expect_at(0, 1, 0, r);
    expect_at(0, 2, 0, r);
  endtask

  task automatic exc_req(logic [7:0] v);
    step(); exc_valid = 1; exc_vec = v;
  endtask

  initial begin
    idle_inputs();
    sr = 16'h2700; reset_sp = 32'h0000_8000; rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R7 reset state
    step(); expect_at(0, 3, 32'h8000, "R7"); expect_at(0, 7, 0, "R7");
    mc_rd(12'h804, 32'h8000, "R7");
    mc_rd(12'h800, 0, "R7");
    mc_rd(12'h803, 0, "R7");
    mc_rd(12'h801, 0, "R7");
    mc_rd(12'h002, 0, "R7");
    mc_rd(12'h000, 0, "R7");
    mc_rd(12'h001, 0, "R7");

    // R1 function-code storage
    mc_wr(12'h000, 32'hFFFF_FFFD);
    mc_wr(12'h001, 32'h0000_0002);
    mc_rd(12'h000, 32'h5, "R1");
    mc_rd(12'h001, 32'h2, "R1");

    // R2 cache-control mask
    mc_wr(12'h002, 32'hFFFF_FFFF);
    mc_rd(12'h002, 32'h3, "R2");
    mc_wr(12'h002, 32'h0000_0006);
    mc_rd(12'h002, 32'h2, "R2");

    // R3 unknown codes
    step(); mc_valid = 1; mc_write = 1; mc_code = 12'h802; mc_wdata = 32'h1234;
    expect_at(0, 1, 1, "R3"); expect_at(0, 0, 0, "R3"); expect_at(0, 2, 0, "R3");
    mc_rd(12'h801, 0, "R3");
    mc_rd(12'h000, 32'h5, "R3");
    step(); mc_valid = 1; mc_code = 12'h005;
    expect_at(0, 1, 1, "R3"); expect_at(0, 0, 0, "R3");

    // R9 vector base relocation
    mc_wr(12'h801, 32'h0000_1000);
    mc_rd(12'h801, 32'h1000, "R9");
    exc_req(8'd5);
    expect_at(1, 6, 32'h1014, "R9"); expect_at(1, 7, 1, "R8");

    // R8 exception entry, trace bits set, all condition codes set
    sr_to(16'hA71F);
    exc_req(8'h40);
    expect_at(1, 5, 32'hA71F, "R8"); expect_at(1, 4, 32'h271F, "R8");
    expect_at(1, 6, 32'h1100, "R9"); expect_at(1, 7, 1, "R8");
    step(); expect_at(1, 7, 0, "R8");
    sr_to(16'h4315);
    expect_at(0, 3, 0, "R5");
    exc_req(8'd0);
    expect_at(1, 5, 32'h4315, "R8"); expect_at(1, 4, 32'h2315, "R8");
    expect_at(1, 6, 32'h1000, "R9");

    // R4 user-mode accesses
    step(); mc_valid = 1; mc_write = 1; mc_code = 12'h800; mc_wdata = 32'h55;
    expect_at(0, 2, 1, "R4"); expect_at(0, 1, 0, "R4");
    step(); mc_valid = 1; mc_code = 12'h802;
    expect_at(0, 2, 1, "R4"); expect_at(0, 1, 0, "R4"); expect_at(0, 0, 0, "R4");
    step(); mc_valid = 1; mc_code = 12'h801;
    expect_at(0, 0, 0, "R4"); expect_at(0, 2, 1, "R4");
    step(); expect_at(0, 3, 0, "R4");
    step(); a7_we = 1; a7_wdata = 32'h444;
    step(); expect_at(0, 3, 32'h444, "R5");

    // R6 user pointer through move-control, R5 banking on S/M changes
    sr_to(16'h2000);
    mc_rd(12'h800, 32'h444, "R6");
    sr_to(16'h3000);
    expect_at(0, 3, 0, "R5");
    step(); a7_we = 1; a7_wdata = 32'h9000;
    mc_rd(12'h803, 32'h9000, "R6");
    mc_rd(12'h804, 32'h8000, "R6");
    sr_to(16'h2000);
    expect_at(0, 3, 32'h8000, "R5");
    mc_wr(12'h804, 32'h7000);
    step(); expect_at(0, 3, 32'h7000, "R6");
    sr_to(16'h3000);
    expect_at(0, 3, 32'h9000, "R5");
    sr_to(16'h2000);

    // R10 simultaneous writes
    step(); mc_valid = 1; mc_write = 1; mc_code = 12'h804; mc_wdata = 32'hAAAA;
    a7_we = 1; a7_wdata = 32'hBBBB;
    mc_rd(12'h804, 32'hAAAA, "R10");
    step(); mc_valid = 1; mc_write = 1; mc_code = 12'h803; mc_wdata = 32'hCCCC;
    a7_we = 1; a7_wdata = 32'hDDDD;
    mc_rd(12'h803, 32'hCCCC, "R10");
    mc_rd(12'h804, 32'hDDDD, "R10");

    step();
    repeat (3) @(posedge clk);
    wait (sbq.size() == 0);
    #1;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule